// File: doc/BRIEF.md
# Residual Branch-and-Join Unit

This block provides the fork and join around a residual block in a streaming activation pipeline. Each input word is copied to two destinations. One copy leaves through a stream port toward an external processing chain, such as a convolution stack, and that chain's result comes back through a second stream port. The other copy waits in a deep bypass FIFO. When the returned main-branch word and the oldest bypass word are both present, the block adds them lane by lane and emits the result through a registered output stage.

Every word packs several lanes of narrow signed activations. The two addends share one scale factor, so the block adds them directly with no shift. Each lane result is clipped to the signed range of the lane width instead of wrapping. All ports use valid/ready handshakes. The join does not assume any fixed latency on either branch. Elements are paired strictly in arrival order.

Top module: `resjoin_unit`

## Requirements
- R1: `in_ready_o` is high exactly when `main_out_ready_i` is high and the bypass FIFO has a free slot. An accepted input word appears unchanged on `main_out_data_o` in the same cycle.
- R2: An input word is transferred to the main branch in a cycle if and only if it is also written into the bypass FIFO. When the FIFO is full, `main_out_valid_o` stays low.
- R3: The bypass FIFO holds exactly DEPTH words. With the return branch idle, DEPTH inputs are accepted and `in_ready_o` then stays low.
- R4: The join consumes a pair only when the returned word is valid, bypass data is present and the output stage can take a result. With the bypass FIFO empty, or the output stage full and not drained, `main_in_ready_o` is low.
- R5: Lane i occupies bits [i*ACT_W +: ACT_W] of every word, in two's complement. Output lane i is the sum of input lanes i, clipped to the range -2^(ACT_W-1) to 2^(ACT_W-1)-1 (for example 7+7 gives 7 and -8+-8 gives -8). Lanes do not interact.
- R6: Under arbitrary independent stalls on the input, the outgoing main branch, the returning main branch and the output, every pair is summed exactly once and in order.
- R7: While `sum_valid_o` is high and `sum_ready_i` is low, the output valid and data hold unchanged in the next cycle.
- R8: After reset, the bypass FIFO is empty and `sum_valid_o` and `main_in_ready_o` are low.
- R9: A sum is presented on `sum_valid_o` in the cycle after its pair is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Input word accepted |
| in_data_i | input | LANES*ACT_W | Input activations |
| main_out_valid_o | output | 1 | Copy to external chain valid |
| main_out_ready_i | input | 1 | External chain ready |
| main_out_data_o | output | LANES*ACT_W | Copy to external chain |
| main_in_valid_i | input | 1 | Returned main-branch word valid |
| main_in_ready_o | output | 1 | Returned word consumed |
| main_in_data_i | input | LANES*ACT_W | Returned main-branch activations |
| sum_valid_o | output | 1 | Sum word valid |
| sum_ready_i | input | 1 | Downstream ready |
| sum_data_o | output | LANES*ACT_W | Clipped lane-wise sum |

## Verification
The bench drives extreme lane values such as 7+7, -8+-8 and -1+-1. A design that wraps instead of clipping, or that lets a carry cross into the next lane, would emit wrong lanes there. It fills the bypass FIFO with the return branch idle. A fork that writes only one branch, or a FIFO with an off-by-one full flag, would accept a word too many or too few. It then holds the output stalled while both branches have data. A join that consumed anyway would drop a sum, and an output register that reloaded would change data while stalled. Long runs with uneven stall patterns on all four handshakes catch any pairing that loses order.

// File: rtl/resjoin_pkg.sv
package resjoin_pkg;
  localparam int unsigned LANES_DEF = 8;
  localparam int unsigned ACT_W_DEF = 4;
  localparam int unsigned DEPTH_DEF = 64;

  function automatic int unsigned ptr_width(int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  function automatic int unsigned cnt_width(int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/resjoin_fork.sv
module resjoin_fork #(
  parameter int unsigned DW = 32
) (
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [DW-1:0] in_data_i,
  output logic          a_valid_o,
  input  logic          a_ready_i,
  output logic [DW-1:0] a_data_o,
  output logic          b_valid_o,
  input  logic          b_ready_i,
  output logic [DW-1:0] b_data_o
);
  // each branch only sees valid when the other can take the same word
  assign in_ready_o = a_ready_i & b_ready_i;
  assign a_valid_o  = in_valid_i & b_ready_i;
  assign b_valid_o  = in_valid_i & a_ready_i;
  assign a_data_o   = in_data_i;
  assign b_data_o   = in_data_i;
endmodule

// File: rtl/resjoin_fifo.sv
module resjoin_fifo
  import resjoin_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_valid_i,
  output logic          push_ready_o,
  input  logic [DW-1:0] push_data_i,
  output logic          pop_valid_o,
  input  logic          pop_ready_i,
  output logic [DW-1:0] pop_data_o
);
  localparam int unsigned AW = ptr_width(DEPTH);
  localparam int unsigned CW = cnt_width(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign push_ready_o = (cnt_q != CW'(DEPTH));
  assign pop_valid_o  = (cnt_q != '0);
  assign pop_data_o   = mem_q[rd_ptr_q];
  assign do_push      = push_valid_i & push_ready_o;
  assign do_pop       = pop_valid_o & pop_ready_i;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/resjoin_lane_sat.sv
module resjoin_lane_sat #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o
);
  localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0] wide;

  assign wide = {a_i[W-1], a_i} + {b_i[W-1], b_i};

  // top two bits disagree -> out of range; sign of wide picks the rail
  always_comb begin
    if (wide[W] != wide[W-1]) s_o = wide[W] ? S_MIN : S_MAX;
    else                      s_o = wide[W-1:0];
  end
endmodule

// File: rtl/resjoin_join.sv
module resjoin_join #(
  parameter int unsigned LANES = 8,
  parameter int unsigned ACT_W = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   main_valid_i,
  output logic                   main_ready_o,
  input  logic [LANES*ACT_W-1:0] main_data_i,
  input  logic                   byp_valid_i,
  output logic                   byp_ready_o,
  input  logic [LANES*ACT_W-1:0] byp_data_i,
  output logic                   sum_valid_o,
  input  logic                   sum_ready_i,
  output logic [LANES*ACT_W-1:0] sum_data_o
);
  localparam int unsigned DW = LANES * ACT_W;

  logic          stage_ready, fire, valid_q;
  logic [DW-1:0] sum_d, sum_q;

  assign stage_ready  = ~valid_q | sum_ready_i;
  assign fire         = main_valid_i & byp_valid_i & stage_ready;
  assign main_ready_o = byp_valid_i & stage_ready;
  assign byp_ready_o  = main_valid_i & stage_ready;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    resjoin_lane_sat #(.W(ACT_W)) u_sat (
      .a_i (main_data_i[l*ACT_W +: ACT_W]),
      .b_i (byp_data_i[l*ACT_W +: ACT_W]),
      .s_o (sum_d[l*ACT_W +: ACT_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      sum_q   <= '0;
    end else begin
      if (stage_ready) valid_q <= fire;
      if (fire)        sum_q   <= sum_d;
    end
  end

  assign sum_valid_o = valid_q;
  assign sum_data_o  = sum_q;
endmodule

// File: rtl/resjoin_unit.sv
module resjoin_unit
  import resjoin_pkg::*;
#(
  parameter int unsigned LANES = LANES_DEF,
  parameter int unsigned ACT_W = ACT_W_DEF,
  parameter int unsigned DEPTH = DEPTH_DEF
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  output logic                   in_ready_o,
  input  logic [LANES*ACT_W-1:0] in_data_i,
  output logic                   main_out_valid_o,
  input  logic                   main_out_ready_i,
  output logic [LANES*ACT_W-1:0] main_out_data_o,
  input  logic                   main_in_valid_i,
  output logic                   main_in_ready_o,
  input  logic [LANES*ACT_W-1:0] main_in_data_i,
  output logic                   sum_valid_o,
  input  logic                   sum_ready_i,
  output logic [LANES*ACT_W-1:0] sum_data_o
);
  localparam int unsigned DW = LANES * ACT_W;

  logic          push_valid, push_ready;
  logic [DW-1:0] push_data;
  logic          byp_valid, byp_ready;
  logic [DW-1:0] byp_data;

  resjoin_fork #(.DW(DW)) u_fork (
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .in_data_i  (in_data_i),
    .a_valid_o  (main_out_valid_o),
    .a_ready_i  (main_out_ready_i),
    .a_data_o   (main_out_data_o),
    .b_valid_o  (push_valid),
    .b_ready_i  (push_ready),
    .b_data_o   (push_data)
  );

  resjoin_fifo #(.DW(DW), .DEPTH(DEPTH)) u_bypass (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_valid_i (push_valid),
    .push_ready_o (push_ready),
    .push_data_i  (push_data),
    .pop_valid_o  (byp_valid),
    .pop_ready_i  (byp_ready),
    .pop_data_o   (byp_data)
  );

  resjoin_join #(.LANES(LANES), .ACT_W(ACT_W)) u_join (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .main_valid_i (main_in_valid_i),
    .main_ready_o (main_in_ready_o),
    .main_data_i  (main_in_data_i),
    .byp_valid_i  (byp_valid),
    .byp_ready_o  (byp_ready),
    .byp_data_i   (byp_data),
    .sum_valid_o  (sum_valid_o),
    .sum_ready_i  (sum_ready_i),
    .sum_data_o   (sum_data_o)
  );
endmodule

// File: rtl/resjoin_unit_chk.sv
module resjoin_unit_chk
  import resjoin_pkg::*;
#(
  parameter int unsigned LANES = LANES_DEF,
  parameter int unsigned ACT_W = ACT_W_DEF,
  parameter int unsigned DEPTH = DEPTH_DEF
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   in_valid_i,
  input logic                   in_ready_o,
  input logic                   main_out_valid_o,
  input logic                   main_out_ready_i,
  input logic                   main_in_valid_i,
  input logic                   main_in_ready_o,
  input logic                   sum_valid_o,
  input logic                   sum_ready_i,
  input logic [LANES*ACT_W-1:0] sum_data_o
);
  localparam int unsigned OW = cnt_width(DEPTH) + 1;

  // bypass occupancy seen from the ports only
  logic [OW-1:0] occ_q;
  logic          push_seen, pop_seen;

  assign push_seen = in_valid_i & in_ready_o;
  assign pop_seen  = main_in_valid_i & main_in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= '0;
    else         occ_q <= occ_q + OW'(push_seen) - OW'(pop_seen);
  end

  assert_fork_pair_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_seen |-> (main_out_valid_o && main_out_ready_i));

  assert_occ_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= OW'(DEPTH));

  assert_full_block_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q == OW'(DEPTH)) |-> !in_ready_o);

  assert_join_empty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q == '0) |-> !main_in_ready_o);

  assert_join_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_seen |=> sum_valid_o);

  assert_out_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_valid_o && !sum_ready_i) |=> (sum_valid_o && $stable(sum_data_o)));
endmodule

bind resjoin_unit resjoin_unit_chk #(
  .LANES (LANES),
  .ACT_W (ACT_W),
  .DEPTH (DEPTH)
) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .in_valid_i       (in_valid_i),
  .in_ready_o       (in_ready_o),
  .main_out_valid_o (main_out_valid_o),
  .main_out_ready_i (main_out_ready_i),
  .main_in_valid_i  (main_in_valid_i),
  .main_in_ready_o  (main_in_ready_o),
  .sum_valid_o      (sum_valid_o),
  .sum_ready_i      (sum_ready_i),
  .sum_data_o       (sum_data_o)
);

// File: tb/resjoin_unit_tb_top.sv
module resjoin_unit_tb_top;
  localparam int LANES = 4;
  localparam int ACT_W = 4;
  localparam int DEPTH = 16;
  localparam int DW    = LANES * ACT_W;
  localparam int HALF  = 1 << (ACT_W - 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, main_out_ready = 1'b0, main_in_valid = 1'b0, sum_ready = 1'b0;
  logic [DW-1:0] in_data = '0, main_in_data = '0;
  logic          in_ready_o, main_out_valid_o, main_in_ready_o, sum_valid_o;
  logic [DW-1:0] main_out_data_o, sum_data_o;

  always #10 clk = ~clk;

  resjoin_unit #(.LANES(LANES), .ACT_W(ACT_W), .DEPTH(DEPTH)) dut_i (
    .clk_i (clk), .rst_ni (rst_n),
    .in_valid_i (in_valid), .in_ready_o (in_ready_o), .in_data_i (in_data),
    .main_out_valid_o (main_out_valid_o), .main_out_ready_i (main_out_ready),
    .main_out_data_o (main_out_data_o),
    .main_in_valid_i (main_in_valid), .main_in_ready_o (main_in_ready_o),
    .main_in_data_i (main_in_data),
    .sum_valid_o (sum_valid_o), .sum_ready_i (sum_ready), .sum_data_o (sum_data_o)
  );

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] byp_q[$], chain_q[$], exp_q[$];
  int  sent = 0, total = 0, cyc = 0, seed = 0, xmode = 0, accepted = 0;
  int  in_mod = 0, mo_mod = 0, mi_mod = 0, so_mod = 0;
  bit  src_on = 0, mi_on = 1, so_on = 1, fixed_on = 0;
  logic [DW-1:0] fixed_word = '0;
  bit  lat_pend = 0, hold_pend = 0;
  logic [DW-1:0] hold_data;
  string sum_req = "R6";

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] gen(int n);
    logic [DW-1:0] w;
    if (fixed_on) return fixed_word;
    for (int l = 0; l < LANES; l++) w[l*ACT_W +: ACT_W] = ACT_W'(n * 5 + l * 11 + seed);
    return w;
  endfunction

  function automatic logic [DW-1:0] xform(logic [DW-1:0] x);
    case (xmode)
      1:       return ~x;
      2:       return {LANES{ACT_W'(HALF - 1)}};
      default: return x;
    endcase
  endfunction

  function automatic logic [DW-1:0] exp_sum(logic [DW-1:0] a, logic [DW-1:0] b);
    logic [DW-1:0] r;
    for (int l = 0; l < LANES; l++) begin
      int av = int'(a[l*ACT_W +: ACT_W]);
      int bv = int'(b[l*ACT_W +: ACT_W]);
      int s;
      if (av >= HALF) av -= 2 * HALF;
      if (bv >= HALF) bv -= 2 * HALF;
      s = av + bv;
      if (s > HALF - 1) s = HALF - 1;
      if (s < -HALF) s = -HALF;
      r[l*ACT_W +: ACT_W] = ACT_W'(s);
    end
    return r;
  endfunction

  function automatic bit gate(int m);
    return !(m != 0 && (cyc % m) == 0);
  endfunction

  task automatic drive();
    in_valid       = src_on && (sent < total) && gate(in_mod);
    in_data        = gen(sent);
    main_out_ready = gate(mo_mod);
    main_in_valid  = mi_on && (chain_q.size() > 0) && gate(mi_mod);
    main_in_data   = main_in_valid ? xform(chain_q[0]) : '0;
    sum_ready      = so_on && gate(so_mod);
  endtask

  task automatic step();
    bit in_f, mo_f, mi_f, so_f;
    logic [DW-1:0] b;
    @(negedge clk);
    cyc++;
    in_f = in_valid && in_ready_o;
    mo_f = main_out_valid_o && main_out_ready;
    mi_f = main_in_valid && main_in_ready_o;
    so_f = sum_valid_o && sum_ready;
    if (lat_pend) begin
      check(sum_valid_o, "R9", 64'(sum_valid_o), 64'd1);
      lat_pend = 0;
    end
    if (hold_pend) begin
      check(sum_valid_o && sum_data_o == hold_data, "R7", 64'(sum_data_o), 64'(hold_data));
      hold_pend = 0;
    end
    if (in_f || mo_f) check(in_f == mo_f, "R2", 64'(mo_f), 64'(in_f));
    if (in_f) begin
      check(main_out_data_o == in_data, "R1", 64'(main_out_data_o), 64'(in_data));
      byp_q.push_back(in_data);
      chain_q.push_back(in_data);
      sent++;
      accepted++;
    end
    if (so_f) begin
      check(exp_q.size() > 0 && sum_data_o == exp_q[0], sum_req, 64'(sum_data_o),
            exp_q.size() > 0 ? 64'(exp_q[0]) : 64'hDEAD);
      if (exp_q.size() > 0) void'(exp_q.pop_front());
    end
    if (mi_f) begin
      check(byp_q.size() > 0, "R4", 64'(byp_q.size()), 64'd1);
      if (byp_q.size() > 0) begin
        b = byp_q.pop_front();
        exp_q.push_back(exp_sum(b, main_in_data));
      end
      void'(chain_q.pop_front());
      lat_pend = 1;
    end
    if (sum_valid_o && !sum_ready) begin
      hold_pend = 1;
      hold_data = sum_data_o;
    end
    @(posedge clk);
    #2;
    drive();
  endtask

  task automatic run_stream(int n, string req);
    int guard = 0;
    total += n;
    src_on = 1;
    while (!(sent == total && byp_q.size() == 0 && chain_q.size() == 0 &&
             exp_q.size() == 0 && !sum_valid_o) && guard < 5000) begin
      step();
      guard++;
    end
    check(sent == total && exp_q.size() == 0, req, 64'(sent), 64'(total));
  endtask

  task automatic t_reset();
    @(negedge clk);
    main_in_valid = 1'b1;
    main_in_data  = '1;
    #1;
    check(!sum_valid_o, "R8", 64'(sum_valid_o), 64'd0);
    check(!main_in_ready_o, "R8", 64'(main_in_ready_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!main_in_ready_o, "R4", 64'(main_in_ready_o), 64'd0);
    main_in_valid = 1'b0;
    main_out_ready = 1'b0;
    #1;
    check(!in_ready_o, "R1", 64'(in_ready_o), 64'd0);
    main_out_ready = 1'b1;
    #1;
    check(in_ready_o, "R1", 64'(in_ready_o), 64'd1);
    @(posedge clk);
    #2;
    drive();
  endtask

  task automatic t_free();
    seed = 3; xmode = 0;
    in_mod = 0; mo_mod = 0; mi_mod = 0; so_mod = 0;
    run_stream(24, "R6");
  endtask

  task automatic t_fill();
    seed = 9; xmode = 1; mi_on = 0; accepted = 0;
    total += DEPTH + 4;
    src_on = 1;
    for (int i = 0; i < DEPTH + 8; i++) step();
    check(accepted == DEPTH, "R3", 64'(accepted), 64'(DEPTH));
    @(negedge clk);
    check(!in_ready_o, "R3", 64'(in_ready_o), 64'd0);
    check(!main_out_valid_o, "R2", 64'(main_out_valid_o), 64'd0);
    @(posedge clk);
    #2;
    mi_on = 1;
    drive();
    run_stream(0, "R3");
  endtask

  task automatic t_stall();
    in_mod = 5; mo_mod = 3; mi_mod = 2; so_mod = 4;
    seed = 1; xmode = 1;
    run_stream(30, "R6");
    seed = 6; xmode = 0; mo_mod = 2; mi_mod = 3; so_mod = 3;
    run_stream(30, "R6");
    in_mod = 0; mo_mod = 0; mi_mod = 0; so_mod = 0;
  endtask

  task automatic t_out_block();
    so_on = 0; seed = 4; xmode = 0;
    total += 6;
    src_on = 1;
    for (int i = 0; i < 12; i++) step();
    @(negedge clk);
    check(sum_valid_o && main_in_valid && byp_q.size() > 0 && !main_in_ready_o,
          "R4", 64'(main_in_ready_o), 64'd0);
    @(posedge clk);
    #2;
    so_on = 1;
    drive();
    run_stream(0, "R4");
  endtask

  task automatic t_sat();
    // lanes 3..0 = -1, -8, 7, 3 ; identity return doubles each lane
    sum_req = "R5"; xmode = 0; fixed_on = 1;
    fixed_word = {4'hF, 4'h8, 4'h7, 4'h3};
    run_stream(3, "R5");
    // all lanes +7 returned: -1+7=6, -8+7=-1, 7+7=7, 3+7=7
    xmode = 2;
    run_stream(3, "R5");
    fixed_word = {4'h8, 4'h0, 4'h9, 4'hC};
    xmode = 0;
    run_stream(2, "R5");
    fixed_on = 0; sum_req = "R6";
  endtask

  initial begin
    t_reset();
    t_free();
    t_fill();
    t_stall();
    t_out_block();
    t_sat();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule